// File: doc/BRIEF.md
# Multi-hit time interval calculator

This block is the digital back end of a counter-plus-interpolator time-to-digital converter. A free-running coarse counter counts reference clock cycles. External interpolators mark each event with a single-cycle strobe and a fine code: the fraction of a clock cycle, in `FINE_STEPS` units, by which the event follows the cycle it is captured in. One start event is followed by up to three stop hits. Each hit has a leading-edge channel and a second channel. In width mode the second channel is the trailing edge. In rise-time mode it is the upper threshold crossing.

The block combines the coarse and fine parts on chip. For each hit it produces the start-to-stop interval and a shape value, which is the time from the hit's leading edge to its second edge. Only these finished numbers are read out, over a mode-0 serial port. A self-test mode replaces the external strobes with a fixed internal event pattern, so the whole arithmetic path can be exercised with no timing source attached. A measurement is armed from idle and ends when all three hits are complete or when a programmable timeout expires. The results are then held until the controller clears them.

Top module: `tdc_hit_calc`

## Requirements
- R1: After reset, `done` is low, the status word reads 0 and every result register reads 0.
- R2: A hit's interval equals (stop coarse count − start coarse count) × FINE_STEPS + stop fine − start fine. A stop fine code smaller than the start fine code borrows correctly from the coarse part (FINE_STEPS = 200 by default).
- R3: Each hit's leading channel accepts only its first strobe after the start. The hit's second channel accepts only its first strobe that comes after that leading capture, on a later cycle. Further strobes are ignored.
- R4: A hit's shape value equals the second-edge timestamp minus the leading-edge timestamp, using the same coarse-times-steps-plus-fine arithmetic.
- R5: The valid flag of a hit is set only when both of its channels were captured. A hit that is not valid reads 0 in both its interval and its shape register.
- R6: With timeout T ≥ 1, a stop strobe that comes n cycles after the start strobe is accepted if n ≤ T and ignored if n > T. `done` rises in the cycle after the strobe at n = T.
- R7: `done` rises once all three hits are valid. It then holds until `clr`, which returns the block to idle and clears the valid flags. An `arm` pulse is ignored unless the block is idle.
- R8: Strobes on the stop channels before the start strobe has been captured are ignored.
- R9: When `bist_en` is set at arm time, the external strobes are ignored and an internal pattern runs. With the defaults, the intervals are 660, 1470 and 2280. The shapes are 395, 385 and 375 in width mode and 195, 185 and 175 in rise-time mode.
- R10: `mode_rise` is sampled at arm time and reported in status bit 3. Changes to the input during a measurement have no effect.
- R11: Serial read format: with `cs_n` low, 8 address bits are sent MSB first on `mosi` and sampled on rising `sclk` edges. Then 32 data bits come MSB first on `miso`, one per later rising edge. Address 0 is status: bits 2:0 are the hit valid flags, bit 3 is the mode, bit 4 is self-test and bit 5 is done. Addresses 1 to 3 hold the intervals of hits 0 to 2, addresses 4 to 6 hold their shapes, and all other addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low reset |
| arm | input | 1 | Starts a measurement when idle |
| clr | input | 1 | Drops results and returns to idle |
| mode_rise | input | 1 | 1 selects rise-time mode, 0 width mode |
| bist_en | input | 1 | Selects the internal event pattern |
| timeout_cyc | input | 24 | Cycles after start during which stops are accepted |
| start_stb | input | 1 | Start event strobe |
| start_fine | input | 8 | Start fine code |
| rise_stb | input | 3 | Leading-edge strobes of hits 0..2 |
| rise_fine | input | 24 | Leading-edge fine codes, hit k at bits 8k+7:8k |
| trail_stb | input | 3 | Second-edge strobes of hits 0..2 |
| trail_fine | input | 24 | Second-edge fine codes, hit k at bits 8k+7:8k |
| done | output | 1 | Measurement finished |
| sclk | input | 1 | Serial clock |
| cs_n | input | 1 | Serial select, active low |
| mosi | input | 1 | Serial address in |
| miso | output | 1 | Serial data out |

## Verification
The external pattern mixes fine codes that are larger and smaller than the start fine. This tells correct borrow arithmetic apart from plain subtraction. The same pattern places stray strobes before the start, before a hit's leading edge and after a capture, which separates first-capture logic from last-capture logic. A timeout run places strobes exactly at and one past the limit, which pins down an off-by-one in the window. Self-test runs in both modes tell the mode-dependent second-edge spacing apart from the external-path muxing.

// File: rtl/tdc_hit_calc.sv
module tdc_hit_calc #(
  parameter int CW = 24,
  parameter int TW = 24,
  parameter int FINE_STEPS = 200,
  parameter int RW = 32,
  parameter int NH = 3,
  localparam int FW = $clog2(FINE_STEPS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            arm,
  input  logic            clr,
  input  logic            mode_rise,
  input  logic            bist_en,
  input  logic [TW-1:0]   timeout_cyc,
  input  logic            start_stb,
  input  logic [FW-1:0]   start_fine,
  input  logic [NH-1:0]   rise_stb,
  input  logic [NH*FW-1:0] rise_fine,
  input  logic [NH-1:0]   trail_stb,
  input  logic [NH*FW-1:0] trail_fine,
  output logic            done,
  input  logic            sclk,
  input  logic            cs_n,
  input  logic            mosi,
  output logic            miso
);
  localparam int NCH = 1 + 2*NH;
  localparam int BW = $clog2(4*NH + 8) + 1;
  localparam logic [FW-1:0] BF_START = FW'(FINE_STEPS*3/4);
  localparam logic [FW-1:0] BF_TRAIL = FW'(FINE_STEPS/40);

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_MEAS, S_DONE} st_t;
  st_t st;

  logic [CW-1:0] cnt;
  logic [TW-1:0] tcnt;
  logic [BW-1:0] bc;
  logic mode_q, bist_q, meas;
  logic [NCH-1:0] ev, b_ev, cap, got;
  logic [FW-1:0] ev_f [NCH];
  logic [FW-1:0] b_f [NCH];
  logic [CW-1:0] ts_c [NCH];
  logic [FW-1:0] ts_f [NCH];
  logic [NH-1:0] hit_ok;
  logic [RW-1:0] ivl [NH];
  logic [RW-1:0] shp [NH];

  function automatic logic [RW-1:0] span(input logic [CW-1:0] ca, input logic [FW-1:0] fa,
                                         input logic [CW-1:0] cb, input logic [FW-1:0] fb);
    logic [CW-1:0] dc;
    dc = cb - ca;
    return RW'(dc) * RW'(FINE_STEPS) + RW'(fb) - RW'(fa);
  endfunction

  assign meas = (st == S_MEAS);
  assign done = (st == S_DONE);

  assign b_ev[0] = (bc == BW'(2));
  assign b_f[0]  = BF_START;
  assign ev[0]   = bist_q ? b_ev[0] : start_stb;
  assign ev_f[0] = bist_q ? b_f[0] : start_fine;
  assign cap[0]  = (st == S_WAIT) && ev[0];

  for (genvar k = 0; k < NH; k++) begin : g_hit
    localparam int R = 1 + k;
    localparam int T = 1 + NH + k;
    assign b_ev[R] = (bc == BW'(2 + 4*(k+1)));
    assign b_ev[T] = (bc == BW'(2 + 4*(k+1)) + (mode_q ? BW'(1) : BW'(2)));
    assign b_f[R]  = FW'((k+1)*FINE_STEPS/20);
    assign b_f[T]  = BF_TRAIL;
    assign ev[R]   = bist_q ? b_ev[R] : rise_stb[k];
    assign ev[T]   = bist_q ? b_ev[T] : trail_stb[k];
    assign ev_f[R] = bist_q ? b_f[R] : rise_fine[k*FW +: FW];
    assign ev_f[T] = bist_q ? b_f[T] : trail_fine[k*FW +: FW];
    assign cap[R]  = meas && ev[R] && !got[R];
    assign cap[T]  = meas && ev[T] && got[R] && !got[T];
    assign hit_ok[k] = got[R] && got[T];
    assign ivl[k] = hit_ok[k] ? span(ts_c[0], ts_f[0], ts_c[R], ts_f[R]) : '0;
    assign shp[k] = hit_ok[k] ? span(ts_c[R], ts_f[R], ts_c[T], ts_f[T]) : '0;
  end

  for (genvar c = 0; c < NCH; c++) begin : g_cap
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        got[c]  <= 1'b0;
        ts_c[c] <= '0;
        ts_f[c] <= '0;
      end else if (clr || (arm && st == S_IDLE)) begin
        got[c] <= 1'b0;
      end else if (cap[c]) begin
        got[c]  <= 1'b1;
        ts_c[c] <= cnt;
        ts_f[c] <= ev_f[c];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      cnt <= '0;
      tcnt <= '0;
      bc <= '0;
      mode_q <= 1'b0;
      bist_q <= 1'b0;
    end else begin
      cnt <= cnt + 1'b1;
      if (st == S_IDLE) bc <= '0;
      else if (bc != '1) bc <= bc + 1'b1;
      if (clr) st <= S_IDLE;
      else case (st)
        S_IDLE: if (arm) begin
          st <= S_WAIT;
          mode_q <= mode_rise;
          bist_q <= bist_en;
        end
        S_WAIT: if (ev[0]) begin
          st <= S_MEAS;
          tcnt <= '0;
        end
        S_MEAS: begin
          tcnt <= tcnt + 1'b1;
          if ((&hit_ok) || tcnt == timeout_cyc - 1'b1) st <= S_DONE;
        end
        default: ;
      endcase
    end
  end

  logic [2:0] s_sck;
  logic [1:0] s_cs, s_mosi;
  logic [5:0] bitn;
  logic [7:0] addr, nxt_addr;
  logic [RW-1:0] sh, rdata;
  logic sck_rise, sck_fall;

  assign sck_rise = s_sck[1] && !s_sck[2];
  assign sck_fall = !s_sck[1] && s_sck[2];
  assign nxt_addr = {addr[6:0], s_mosi[1]};
  assign miso = sh[RW-1];

  always_comb begin
    rdata = '0;
    if (nxt_addr == 8'd0) rdata = RW'({done, bist_q, mode_q, hit_ok});
    for (int k = 0; k < NH; k++) begin
      if (nxt_addr == 8'(1 + k)) rdata = ivl[k];
      if (nxt_addr == 8'(1 + NH + k)) rdata = shp[k];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_sck <= '0;
      s_cs <= '1;
      s_mosi <= '0;
      bitn <= '0;
      addr <= '0;
      sh <= '0;
    end else begin
      s_sck <= {s_sck[1:0], sclk};
      s_cs <= {s_cs[0], cs_n};
      s_mosi <= {s_mosi[0], mosi};
      if (s_cs[1]) bitn <= '0;
      else if (sck_rise) begin
        bitn <= bitn + 1'b1;
        if (bitn < 6'd8) addr <= nxt_addr;
        if (bitn == 6'd7) sh <= rdata;
      end else if (sck_fall && bitn >= 6'd9) begin
        sh <= {sh[RW-2:0], 1'b0};
      end
    end
  end
endmodule

// File: rtl/tdc_hit_calc_chk.sv
module tdc_hit_calc_chk #(parameter int NH = 3) (
  input logic          clk,
  input logic          rst_n,
  input logic          clr,
  input logic          done,
  input logic          meas,
  input logic [NH-1:0] hit_ok
);
  a_r7_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
    done && !clr |=> done);
  a_r7_clr_idles: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !done);
  a_r5_valid_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    done && !clr |=> $stable(hit_ok));
  a_r6_done_after_meas: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(meas));
endmodule

bind tdc_hit_calc tdc_hit_calc_chk #(.NH(NH)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr), .done(done), .meas(meas), .hit_ok(hit_ok)
);

// File: tb/tb_tdc_hit_calc.sv
module tb_tdc_hit_calc;
  logic clk = 0, rst_n = 0, arm = 0, clr = 0, mode_rise = 0, bist_en = 0;
  logic [23:0] timeout_cyc = 24'd1000;
  logic start_stb = 0;
  logic [7:0] start_fine = 0;
  logic [2:0] rise_stb = 0, trail_stb = 0;
  logic [23:0] rise_fine = 0, trail_fine = 0;
  logic done, sclk = 0, cs_n = 1, mosi = 0, miso;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  tdc_hit_calc dut (.clk(clk), .rst_n(rst_n), .arm(arm), .clr(clr), .mode_rise(mode_rise),
    .bist_en(bist_en), .timeout_cyc(timeout_cyc), .start_stb(start_stb), .start_fine(start_fine),
    .rise_stb(rise_stb), .rise_fine(rise_fine), .trail_stb(trail_stb), .trail_fine(trail_fine),
    .done(done), .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tick(input logic s, input logic [2:0] r, input logic [2:0] t);
    start_stb = s; rise_stb = r; trail_stb = t;
    @(negedge clk);
    start_stb = 0; rise_stb = 0; trail_stb = 0;
  endtask

  task automatic spi_read(input logic [7:0] a, output logic [31:0] d);
    cs_n = 0; idle(6);
    for (int i = 0; i < 8; i++) begin
      mosi = a[7-i]; idle(6); sclk = 1; idle(6); sclk = 0;
    end
    for (int i = 0; i < 32; i++) begin
      idle(6); d[31-i] = miso; sclk = 1; idle(6); sclk = 0;
    end
    idle(6); cs_n = 1; idle(6);
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    spi_read(a, d);
    chk(tag, d, exp);
  endtask

  task automatic do_arm(input logic m, input logic b, input logic [23:0] tmo);
    mode_rise = m; bist_en = b; timeout_cyc = tmo; arm = 1;
    @(negedge clk);
    arm = 0;
  endtask

  task automatic do_clr();
    clr = 1; @(negedge clk); clr = 0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 300 && !done; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 done after reset", done, 0);
    rd_chk("R1 status after reset", 8'd0, 0);
    rd_chk("R1 interval0 after reset", 8'd1, 0);
  endtask

  task automatic t_external();
    do_arm(0, 0, 24'd1000);
    rise_fine[23:16] = 99; tick(0, 3'b100, 0);            // R8 pre-start stop
    start_fine = 20; tick(1, 0, 0);                        // E0
    idle(2);
    trail_fine[15:8] = 77; tick(0, 0, 3'b010);             // E3, R3 second edge before lead
    idle(1);
    rise_fine[7:0] = 50; tick(0, 3'b001, 0);               // E5
    idle(1);
    trail_fine[7:0] = 30; tick(0, 0, 3'b001);              // E7
    rise_fine[7:0] = 120; tick(0, 3'b001, 0);              // E8, R3 repeat ignored
    idle(1);
    rise_fine[15:8] = 10; tick(0, 3'b010, 0);              // E10, borrow
    trail_fine[15:8] = 190; tick(0, 0, 3'b010);            // E11
    idle(8);
    rise_fine[23:16] = 20; tick(0, 3'b100, 0);             // E20
    idle(5);
    trail_fine[23:16] = 0; tick(0, 0, 3'b100);             // E26
    wait_done();
    chk("R7 done after three hits", done, 1);
    rd_chk("R11 status external", 8'd0, 32'h27);
    rd_chk("R2 interval hit0", 8'd1, 1030);
    rd_chk("R2 interval hit1 borrow", 8'd2, 1990);
    rd_chk("R8 interval hit2", 8'd3, 4000);
    rd_chk("R4 shape hit0", 8'd4, 380);
    rd_chk("R3 shape hit1", 8'd5, 380);
    rd_chk("R4 shape hit2", 8'd6, 1180);
    do_arm(1, 1, 24'd5);
    idle(3);
    rd_chk("R7 arm ignored when done", 8'd0, 32'h27);
    do_clr();
    chk("R7 done cleared", done, 0);
    rd_chk("R7 status after clr", 8'd0, 0);
  endtask

  task automatic t_timeout();
    do_arm(1, 0, 24'd10);
    mode_rise = 0;                                         // R10 change ignored
    start_fine = 0; tick(1, 0, 0);                         // E0
    idle(3);
    rise_fine[7:0] = 100; tick(0, 3'b001, 0);              // E4
    idle(5);                                               // E5..E9
    chk("R6 done low before limit", done, 0);
    trail_fine[7:0] = 0; rise_fine[15:8] = 7; tick(0, 3'b010, 3'b001); // E10
    chk("R6 done at limit", done, 1);
    tick(0, 0, 3'b010);                                    // E11 rejected
    rd_chk("R10 status timeout", 8'd0, 32'h29);
    rd_chk("R6 interval hit0", 8'd1, 900);
    rd_chk("R6 shape hit0 at limit", 8'd4, 1100);
    rd_chk("R5 interval hit1 invalid", 8'd2, 0);
    rd_chk("R5 shape hit1 invalid", 8'd5, 0);
    do_clr();
  endtask

  task automatic t_bist(input logic m);
    logic [31:0] s0, s1, s2;
    do_arm(m, 1, 24'd1000);
    for (int i = 0; i < 24; i++) tick(1, 3'b111, 3'b111);  // external ignored
    wait_done();
    s0 = m ? 195 : 395; s1 = m ? 185 : 385; s2 = m ? 175 : 375;
    rd_chk("R9 bist status", 8'd0, m ? 32'h3F : 32'h37);
    rd_chk("R9 bist interval0", 8'd1, 660);
    rd_chk("R9 bist interval1", 8'd2, 1470);
    rd_chk("R9 bist interval2", 8'd3, 2280);
    rd_chk("R9 bist shape0", 8'd4, s0);
    rd_chk("R9 bist shape1", 8'd5, s1);
    rd_chk("R9 bist shape2", 8'd6, s2);
    rd_chk("R11 unmapped address", 8'd7, 0);
    do_clr();
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual 1 expected 0");
    summary();
  end

  initial begin
    idle(5);
    rst_n = 1;
    idle(2);
    t_reset();
    t_external();
    t_timeout();
    t_bist(0);
    t_bist(1);
    summary();
  end
endmodule